// File: doc/BRIEF.md
# Hybrid Look-Ahead Fault-Tolerant Route Unit

This block computes the route for the head flit of one input port of a router in a three-dimensional mesh. The upstream router has already chosen the port this flit should leave by here (the look-ahead port). The unit first checks whether that choice heads into a dead end. A dead end is a neighbour whose every minimal link toward the destination is faulty. If the look-ahead port is safe, it is passed on as the out-port unchanged. If it is a dead end, the out-port is recomputed here from the link status of this node. In both cases the unit also computes the look-ahead port that the next router will use, and reports it with the out-port.

Each candidate is ranked on three criteria, in this order. A minimal, non-faulty direction comes first. Next comes path diversity: the number of dimensions in which the candidate neighbour still differs from the destination. Last comes a free (non-stalled) output. Any remaining tie goes to the lowest port code.

A small state machine sequences the work:
- IDLE accepts a flit.
- CHECK evaluates the dead-end flag.
- LOCAL recomputes the out-port. It is entered only when the flag is raised.
- EMIT presents the result for one cycle.

The transitions are IDLE→CHECK on `in_valid`, CHECK→EMIT when the flag is clear, CHECK→LOCAL when it is set, LOCAL→EMIT, and EMIT→IDLE.

Top module: `hlr_route_unit`

## Requirements
- R1: During and right after reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Port codes are Local=0, East=1 (+x), West=2 (−x), North=3 (+y), South=4 (−y), Up=5 (+z), Down=6 (−z). A safe look-ahead port is passed through with `out_recomp`=0. Here the look-ahead port is `in_np`, and the neighbour it enters is the current coordinates stepped one hop along it. Safe means that neighbour has at least one non-faulty minimal link. `out_valid` is then high for exactly one cycle, in the cycle after the first clock edge following the accepting edge.
- R3: The dead-end flag is raised when every minimal link of the neighbour is faulty. The neighbour's link toward port q is `nbr_fault[(p-1)*6 + q-1]`, where p is the port leading to that neighbour. When the flag is raised, `out_recomp`=1 and the result appears one cycle later than in R2.
- R4: A flit whose destination equals the neighbour is never flagged. Its new next-port is Local, whatever that neighbour's links are.
- R5: A recomputed out-port never uses a link marked in `cur_fault` (bit p-1 for port p). It never re-selects `in_np` and never leaves the mesh. A minimal direction always outranks a nonminimal one. If no candidate remains, `in_np` is kept.
- R6: Among recomputed candidates of equal minimality, the one with larger diversity wins. Diversity counts the dimensions in which that neighbour differs from the destination, and a neighbour equal to the destination counts as 3.
- R7: After minimality and diversity, a port whose stall bit `cong[p-1]` is 0 beats a stalled one. Any remaining tie goes to the lowest port code.
- R8: A recomputed out-port never equals the arrival port `in_arr`. A nonminimal port is also excluded when the link opposite it at this node is faulty.
- R9: `out_next` is computed from the node reached through `out_port`. It is that node's minimal, non-faulty direction with the largest diversity, lowest code on a tie. If all of them are faulty, it is the lowest-code minimal direction.
- R10: When `in_np` is Local, both `out_port` and `out_next` are Local and `out_recomp` is 0.
- R11: `in_valid` is taken only while `in_ready` is high. Stimulus offered in any other cycle produces no result and does not alter the pending one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Head flit fields are present |
| in_ready | output | 1 | Unit is idle and will take a flit |
| in_np | input | 3 | Look-ahead port carried in the flit |
| in_arr | input | 3 | Port the flit arrived on |
| cur_x | input | XW | Current node x |
| cur_y | input | YW | Current node y |
| cur_z | input | ZW | Current node z |
| dst_x | input | XW | Destination x |
| dst_y | input | YW | Destination y |
| dst_z | input | ZW | Destination z |
| cur_fault | input | 6 | Fault bit per link of this node, bit p-1 for port p |
| nbr_fault | input | 36 | Six fault bits for each neighbour, neighbour p at bits (p-1)*6 up |
| cong | input | 6 | Stall bit per output port of this node |
| out_valid | output | 1 | Result present (one cycle) |
| out_port | output | 3 | Out-port at this node |
| out_next | output | 3 | Look-ahead port for the next node |
| out_recomp | output | 1 | Out-port came from local recomputation |

## Verification
The assertions assume that `in_np` names a direction that keeps the flit inside the mesh, and that it is Local only when the current node is the destination. They also assume that the fault, stall and coordinate fields are constant during the accepting cycle. The bench respects this by always deriving `in_np` from a minimal direction between the current node and the destination. It holds every field from one falling edge to the next. The arrival port and all fault and stall bits are free. That lets dead ends, blocked turn-backs and empty candidate sets arise in the random part.

// File: rtl/hlr_pkg.sv
package hlr_pkg;

    localparam int NL  = 6;
    localparam int NBW = NL * NL;

    typedef enum logic [2:0] {
        PORT_LOC = 3'd0,
        PORT_E   = 3'd1,
        PORT_W   = 3'd2,
        PORT_N   = 3'd3,
        PORT_S   = 3'd4,
        PORT_U   = 3'd5,
        PORT_D   = 3'd6
    } port_e;

    function automatic int off_x(logic [2:0] p);
        case (p)
            3'd1:    return 1;
            3'd2:    return -1;
            default: return 0;
        endcase
    endfunction

    function automatic int off_y(logic [2:0] p);
        case (p)
            3'd3:    return 1;
            3'd4:    return -1;
            default: return 0;
        endcase
    endfunction

    function automatic int off_z(logic [2:0] p);
        case (p)
            3'd5:    return 1;
            3'd6:    return -1;
            default: return 0;
        endcase
    endfunction

    function automatic logic [2:0] opp(logic [2:0] p);
        if (p == 3'd0) return 3'd0;
        return p[0] ? p + 3'd1 : p - 3'd1;
    endfunction

    // minimal directions from node n toward d, bit p-1 for port p
    function automatic logic [5:0] min_dirs(int nx, int ny, int nz, int dx, int dy, int dz);
        logic [5:0] m;
        m = '0;
        m[0] = dx > nx;
        m[1] = dx < nx;
        m[2] = dy > ny;
        m[3] = dy < ny;
        m[4] = dz > nz;
        m[5] = dz < nz;
        return m;
    endfunction

    function automatic logic [1:0] spread(int nx, int ny, int nz, int dx, int dy, int dz);
        int c;
        c = 0;
        if (nx != dx) c++;
        if (ny != dy) c++;
        if (nz != dz) c++;
        return 2'(c);
    endfunction

endpackage

// File: rtl/hlr_fault_check.sv
module hlr_fault_check
    import hlr_pkg::*;
#(
    parameter int XW = 2,
    parameter int YW = 2,
    parameter int ZW = 2
) (
    input  logic [2:0]     np,
    input  logic [XW-1:0]  cur_x,
    input  logic [YW-1:0]  cur_y,
    input  logic [ZW-1:0]  cur_z,
    input  logic [XW-1:0]  dst_x,
    input  logic [YW-1:0]  dst_y,
    input  logic [ZW-1:0]  dst_z,
    input  logic [NBW-1:0] nbr_fault,
    output logic           dead_end
);

    int         nx, ny, nz, base;
    logic       at_dst;
    logic [5:0] mm, lk;

    always_comb begin
        nx     = int'(cur_x) + off_x(np);
        ny     = int'(cur_y) + off_y(np);
        nz     = int'(cur_z) + off_z(np);
        at_dst = (nx == int'(dst_x)) && (ny == int'(dst_y)) && (nz == int'(dst_z));
        base   = (np >= 3'd1 && np <= 3'd6) ? (int'(np) - 1) * NL : 0;
        lk     = nbr_fault[base +: NL];
        mm     = min_dirs(nx, ny, nz, int'(dst_x), int'(dst_y), int'(dst_z));
        dead_end = (np != PORT_LOC) && !at_dst && (mm != '0) && ((mm & ~lk) == '0);
    end

endmodule

// File: rtl/hlr_local_rc.sv
module hlr_local_rc
    import hlr_pkg::*;
#(
    parameter int NX = 4,
    parameter int NY = 4,
    parameter int NZ = 4,
    parameter int XW = 2,
    parameter int YW = 2,
    parameter int ZW = 2
) (
    input  logic [2:0]    np,
    input  logic [2:0]    arr,
    input  logic [XW-1:0] cur_x,
    input  logic [YW-1:0] cur_y,
    input  logic [ZW-1:0] cur_z,
    input  logic [XW-1:0] dst_x,
    input  logic [YW-1:0] dst_y,
    input  logic [ZW-1:0] dst_z,
    input  logic [NL-1:0] cur_fault,
    input  logic [NL-1:0] cong,
    output logic [2:0]    sel_port,
    output logic          sel_found
);

    logic [5:0]      cmin;
    logic [NL:1]     cand_ok;
    logic [NL:1][3:0] cand_key;
    logic [3:0]      best_key;

    assign cmin = min_dirs(int'(cur_x), int'(cur_y), int'(cur_z),
                           int'(dst_x), int'(dst_y), int'(dst_z));

    for (genvar g = 1; g <= NL; g++) begin : g_cand
        localparam logic [2:0] PG = 3'(g);
        localparam int         PO = int'(opp(PG));
        int         px, py, pz;
        logic       in_mesh, is_min, hits_dst;
        logic [1:0] div;

        assign px       = int'(cur_x) + off_x(PG);
        assign py       = int'(cur_y) + off_y(PG);
        assign pz       = int'(cur_z) + off_z(PG);
        assign in_mesh  = (px >= 0) && (px < NX) && (py >= 0) && (py < NY)
                        && (pz >= 0) && (pz < NZ);
        assign is_min   = cmin[g-1];
        assign hits_dst = (px == int'(dst_x)) && (py == int'(dst_y)) && (pz == int'(dst_z));
        assign div      = hits_dst ? 2'd3
                        : spread(px, py, pz, int'(dst_x), int'(dst_y), int'(dst_z));
        assign cand_ok[g]  = in_mesh && !cur_fault[g-1] && (PG != np) && (PG != arr)
                           && (is_min || !cur_fault[PO-1]);
        assign cand_key[g] = {is_min, div, ~cong[g-1]};
    end

    always_comb begin
        sel_port  = np;
        sel_found = 1'b0;
        best_key  = '0;
        for (int i = 1; i <= NL; i++) begin
            if (cand_ok[i] && (!sel_found || cand_key[i] > best_key)) begin
                sel_found = 1'b1;
                best_key  = cand_key[i];
                sel_port  = 3'(i);
            end
        end
    end

endmodule

// File: rtl/hlr_lookahead.sv
module hlr_lookahead
    import hlr_pkg::*;
#(
    parameter int XW = 2,
    parameter int YW = 2,
    parameter int ZW = 2
) (
    input  logic [2:0]     chosen,
    input  logic [XW-1:0]  cur_x,
    input  logic [YW-1:0]  cur_y,
    input  logic [ZW-1:0]  cur_z,
    input  logic [XW-1:0]  dst_x,
    input  logic [YW-1:0]  dst_y,
    input  logic [ZW-1:0]  dst_z,
    input  logic [NBW-1:0] nbr_fault,
    output logic [2:0]     next_port
);

    int         mx, my, mz, base, best, dv;
    logic       hit, at_dst;
    logic [5:0] mm, lk;

    always_comb begin
        mx     = int'(cur_x) + off_x(chosen);
        my     = int'(cur_y) + off_y(chosen);
        mz     = int'(cur_z) + off_z(chosen);
        at_dst = (mx == int'(dst_x)) && (my == int'(dst_y)) && (mz == int'(dst_z));
        base   = (chosen >= 3'd1 && chosen <= 3'd6) ? (int'(chosen) - 1) * NL : 0;
        lk     = nbr_fault[base +: NL];
        mm     = min_dirs(mx, my, mz, int'(dst_x), int'(dst_y), int'(dst_z));
        next_port = PORT_LOC;
        hit    = 1'b0;
        best   = 0;
        dv     = 0;
        if (chosen != PORT_LOC && !at_dst) begin
            for (int q = 1; q <= NL; q++) begin
                if (mm[q-1] && !lk[q-1]) begin
                    dv = int'(spread(mx + off_x(3'(q)), my + off_y(3'(q)), mz + off_z(3'(q)),
                                     int'(dst_x), int'(dst_y), int'(dst_z)));
                    if (!hit || dv > best) begin
                        hit       = 1'b1;
                        best      = dv;
                        next_port = 3'(q);
                    end
                end
            end
            if (!hit) begin
                for (int q = NL; q >= 1; q--) begin
                    if (mm[q-1]) next_port = 3'(q);
                end
            end
        end
    end

endmodule

// File: rtl/hlr_route_unit.sv
module hlr_route_unit
    import hlr_pkg::*;
#(
    parameter int  NX = 4,
    parameter int  NY = 4,
    parameter int  NZ = 4,
    localparam int XW = (NX > 1) ? $clog2(NX) : 1,
    localparam int YW = (NY > 1) ? $clog2(NY) : 1,
    localparam int ZW = (NZ > 1) ? $clog2(NZ) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [2:0]    in_np,
    input  logic [2:0]    in_arr,
    input  logic [XW-1:0] cur_x,
    input  logic [YW-1:0] cur_y,
    input  logic [ZW-1:0] cur_z,
    input  logic [XW-1:0] dst_x,
    input  logic [YW-1:0] dst_y,
    input  logic [ZW-1:0] dst_z,
    input  logic [5:0]    cur_fault,
    input  logic [35:0]   nbr_fault,
    input  logic [5:0]    cong,
    output logic          out_valid,
    output logic [2:0]    out_port,
    output logic [2:0]    out_next,
    output logic          out_recomp
);

    typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_LOCAL, ST_EMIT} state_e;

    state_e          state_q, state_d;
    logic [2:0]      np_q, arr_q, chosen_q;
    logic [XW-1:0]   cx_q, dx_q;
    logic [YW-1:0]   cy_q, dy_q;
    logic [ZW-1:0]   cz_q, dz_q;
    logic [NL-1:0]   cf_q, cg_q;
    logic [NBW-1:0]  nf_q;
    logic            recomp_q, found_q;
    logic            dead_end, sel_found;
    logic [2:0]      sel_port, la_next;

    hlr_fault_check #(.XW(XW), .YW(YW), .ZW(ZW)) u_check (
        .np(np_q), .cur_x(cx_q), .cur_y(cy_q), .cur_z(cz_q),
        .dst_x(dx_q), .dst_y(dy_q), .dst_z(dz_q),
        .nbr_fault(nf_q), .dead_end(dead_end)
    );

    hlr_local_rc #(.NX(NX), .NY(NY), .NZ(NZ), .XW(XW), .YW(YW), .ZW(ZW)) u_local (
        .np(np_q), .arr(arr_q), .cur_x(cx_q), .cur_y(cy_q), .cur_z(cz_q),
        .dst_x(dx_q), .dst_y(dy_q), .dst_z(dz_q),
        .cur_fault(cf_q), .cong(cg_q), .sel_port(sel_port), .sel_found(sel_found)
    );

    hlr_lookahead #(.XW(XW), .YW(YW), .ZW(ZW)) u_la (
        .chosen(chosen_q), .cur_x(cx_q), .cur_y(cy_q), .cur_z(cz_q),
        .dst_x(dx_q), .dst_y(dy_q), .dst_z(dz_q),
        .nbr_fault(nf_q), .next_port(la_next)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (in_valid) state_d = ST_CHECK;
            ST_CHECK: state_d = dead_end ? ST_LOCAL : ST_EMIT;
            ST_LOCAL: state_d = ST_EMIT;
            ST_EMIT:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            np_q <= '0; arr_q <= '0; chosen_q <= '0;
            cx_q <= '0; cy_q <= '0; cz_q <= '0;
            dx_q <= '0; dy_q <= '0; dz_q <= '0;
            cf_q <= '0; cg_q <= '0; nf_q <= '0;
            recomp_q <= 1'b0; found_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (in_valid) begin
                    np_q <= in_np; arr_q <= in_arr;
                    cx_q <= cur_x; cy_q <= cur_y; cz_q <= cur_z;
                    dx_q <= dst_x; dy_q <= dst_y; dz_q <= dst_z;
                    cf_q <= cur_fault; nf_q <= nbr_fault; cg_q <= cong;
                end
                ST_CHECK: if (!dead_end) begin
                    chosen_q <= np_q;
                    recomp_q <= 1'b0;
                    found_q  <= 1'b1;
                end
                ST_LOCAL: begin
                    chosen_q <= sel_port;
                    recomp_q <= 1'b1;
                    found_q  <= sel_found;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        in_ready   = (state_q == ST_IDLE);
        out_valid  = (state_q == ST_EMIT);
        out_port   = chosen_q;
        out_next   = la_next;
        out_recomp = recomp_q;
    end

    // node reached through the emitted out-port
    int hx, hy, hz;
    always_comb begin
        hx = int'(cx_q) + off_x(chosen_q);
        hy = int'(cy_q) + off_y(chosen_q);
        hz = int'(cz_q) + off_z(chosen_q);
    end

    p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    p_pass_keeps_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_recomp |-> out_port == np_q);

    p_avoid_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_recomp && found_q |-> !cf_q[out_port - 3'd1] && out_port != np_q);

    p_no_turnback_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_recomp && found_q |-> out_port != arr_q);

    p_dest_local_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_port != PORT_LOC && hx == int'(dx_q) && hy == int'(dy_q)
        && hz == int'(dz_q) |-> out_next == PORT_LOC && !out_recomp);

    p_local_local_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_port == PORT_LOC |-> out_next == PORT_LOC);

    p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready && in_valid |=> $stable(np_q) && $stable(nf_q));

endmodule

// File: tb/sim_hlr_route_unit.sv
module sim_hlr_route_unit;

    localparam int NX = 4, NY = 4, NZ = 4;

    typedef struct packed {
        logic [2:0]  port;
        logic [2:0]  nxt;
        logic        rc;
        logic [31:0] acc;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  in_np = '0, in_arr = '0;
    logic [1:0]  cur_x = '0, cur_y = '0, cur_z = '0;
    logic [1:0]  dst_x = '0, dst_y = '0, dst_z = '0;
    logic [5:0]  cur_fault = '0, cong = '0;
    logic [35:0] nbr_fault = '0;
    logic        out_valid, out_recomp;
    logic [2:0]  out_port, out_next;

    int checks = 0, failures = 0, sent = 0, seen = 0;
    logic [31:0] cyc = '0;
    exp_t  expq[$];
    string tagq[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hlr_route_unit #(.NX(NX), .NY(NY), .NZ(NZ)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_np(in_np), .in_arr(in_arr),
        .cur_x(cur_x), .cur_y(cur_y), .cur_z(cur_z),
        .dst_x(dst_x), .dst_y(dst_y), .dst_z(dst_z),
        .cur_fault(cur_fault), .nbr_fault(nbr_fault), .cong(cong),
        .out_valid(out_valid), .out_port(out_port), .out_next(out_next),
        .out_recomp(out_recomp)
    );

    task automatic chk(input bit ok, input string tag, input string what);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    // ---------- reference model, written from the requirements ----------
    function automatic void mv(input int p, inout int x, inout int y, inout int z);
        int k, s;
        if (p == 0) return;
        k = (p - 1) / 2;
        s = (p % 2 == 1) ? 1 : -1;
        if (k == 0) x += s; else if (k == 1) y += s; else z += s;
    endfunction

    function automatic int mmask(int x, int y, int z, int dx, int dy, int dz);
        int m = 0;
        if (dx > x) m |= 1;  if (dx < x) m |= 2;
        if (dy > y) m |= 4;  if (dy < y) m |= 8;
        if (dz > z) m |= 16; if (dz < z) m |= 32;
        return m;
    endfunction

    function automatic int ndiff(int x, int y, int z, int dx, int dy, int dz);
        return int'(x != dx) + int'(y != dy) + int'(z != dz);
    endfunction

    function automatic void model(input int cx, cy, cz, dx, dy, dz, np, arr,
                                  input logic [5:0] cf, input logic [35:0] nf,
                                  input logic [5:0] cg,
                                  output logic [2:0] port, output logic [2:0] nxt,
                                  output logic rc);
        int x, y, z, m, lk, best, sc, mn, op, dv, p;
        bit ok;
        x = cx; y = cy; z = cz; mv(np, x, y, z);
        rc = 0; p = np;
        if (np != 0 && !(x == dx && y == dy && z == dz)) begin
            m  = mmask(x, y, z, dx, dy, dz);
            lk = int'((nf >> ((np - 1) * 6)) & 36'h3f);
            if ((m & ~lk) == 0) rc = 1;
        end
        if (rc) begin
            best = -1;
            for (int q = 1; q <= 6; q++) begin
                x = cx; y = cy; z = cz; mv(q, x, y, z);
                ok = x >= 0 && x < NX && y >= 0 && y < NY && z >= 0 && z < NZ
                     && !cf[q-1] && q != np && q != arr;
                mn = (mmask(cx, cy, cz, dx, dy, dz) >> (q - 1)) & 1;
                op = (q % 2 == 1) ? q + 1 : q - 1;
                if (mn == 0 && cf[op-1]) ok = 0;
                dv = (x == dx && y == dy && z == dz) ? 3 : ndiff(x, y, z, dx, dy, dz);
                sc = mn * 8 + dv * 2 + (cg[q-1] ? 0 : 1);
                if (ok && sc > best) begin best = sc; p = q; end
            end
        end
        port = 3'(p);
        nxt  = 3'd0;
        if (p != 0) begin
            x = cx; y = cy; z = cz; mv(p, x, y, z);
            if (!(x == dx && y == dy && z == dz)) begin
                m  = mmask(x, y, z, dx, dy, dz);
                lk = int'((nf >> ((p - 1) * 6)) & 36'h3f);
                best = -1;
                for (int q = 1; q <= 6; q++) begin
                    if (((m >> (q - 1)) & 1) == 1 && ((lk >> (q - 1)) & 1) == 0) begin
                        int ax = x, ay = y, az = z;
                        mv(q, ax, ay, az);
                        dv = ndiff(ax, ay, az, dx, dy, dz);
                        if (dv > best) begin best = dv; nxt = 3'(q); end
                    end
                end
                if (best < 0)
                    for (int q = 6; q >= 1; q--)
                        if (((m >> (q - 1)) & 1) == 1) nxt = 3'(q);
            end
        end
    endfunction

    // ---------- driver ----------
    task automatic send(input int cx, cy, cz, dx, dy, dz, np, arr,
                        input logic [5:0] cf, input logic [35:0] nf,
                        input logic [5:0] cg, input string tag);
        exp_t e;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        model(cx, cy, cz, dx, dy, dz, np, arr, cf, nf, cg, e.port, e.nxt, e.rc);
        e.acc = cyc + 1;
        in_valid = 1'b1;
        in_np = 3'(np); in_arr = 3'(arr);
        cur_x = 2'(cx); cur_y = 2'(cy); cur_z = 2'(cz);
        dst_x = 2'(dx); dst_y = 2'(dy); dst_z = 2'(dz);
        cur_fault = cf; nbr_fault = nf; cong = cg;
        expq.push_back(e);
        tagq.push_back(tag);
        sent++;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // ---------- monitor ----------
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            seen++;
            if (expq.size() == 0) begin
                chk(1'b0, "R11", $sformatf("unexpected result port=%0d expected none", out_port));
            end else begin
                exp_t  e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                chk(out_port == e.port && out_next == e.nxt && out_recomp == e.rc, t,
                    $sformatf("port/next/recomp actual=%0d/%0d/%0d expected=%0d/%0d/%0d",
                              out_port, out_next, out_recomp, e.port, e.nxt, e.rc));
                chk(cyc - e.acc == (e.rc ? 32'd2 : 32'd1), e.rc ? "R3" : "R2",
                    $sformatf("latency actual=%0d expected=%0d", cyc - e.acc, e.rc ? 2 : 1));
            end
        end
    end

    // ---------- watchdog ----------
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // ---------- stimulus ----------
    initial begin
        logic [35:0] nf;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", $sformatf("out_valid in reset actual=%0d expected=0", out_valid));
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R1",
            $sformatf("ready/valid actual=%0d/%0d expected=1/0", in_ready, out_valid));

        // R2 R9: safe East hop, look-ahead picks North (diversity 3, lowest code)
        send(1,1,1, 3,3,3, 1, 0, 6'h00, 36'h0, 6'h00, "R2 R9");
        // R3 R5 R7: East neighbour has E,N,U faulty -> recompute, N/U tie -> North
        nf = 36'h0; nf[0] = 1; nf[2] = 1; nf[4] = 1;
        send(1,1,1, 3,3,3, 1, 0, 6'h00, nf, 6'h00, "R3 R5 R7");
        // R7: North stalled -> Up
        send(1,1,1, 3,3,3, 1, 0, 6'h00, nf, 6'h04, "R7");
        // R6: Up (diversity 3) beats North (diversity 2), even when Up is stalled
        send(1,1,1, 3,2,3, 1, 0, 6'h00, nf, 6'h10, "R6");
        // R4: destination is the neighbour; its links all faulty, no flag
        send(1,1,1, 2,1,1, 1, 0, 6'h00, {30'h0, 6'h3f}, 6'h00, "R4");
        // R10: already at destination
        send(2,2,2, 2,2,2, 0, 1, 6'h3f, 36'hfffffffff, 6'h3f, "R10");
        // R8: arrival North excluded, Down faulty forbids Up, South faulty -> West
        nf = 36'h0; nf[0] = 1;
        send(1,1,1, 3,1,1, 1, 3, 6'h28, nf, 6'h00, "R8");
        // R8: South faulty forbids North (nonminimal) -> Up
        send(1,1,1, 3,1,1, 1, 0, 6'h08, nf, 6'h00, "R8");
        // R5: every other link faulty -> no candidate, keep look-ahead port
        send(1,1,1, 3,1,1, 1, 0, 6'h3e, nf, 6'h00, "R5");
        // R5: mesh corner, off-mesh ports never chosen
        nf = 36'h0; nf[0] = 1; nf[2] = 1;
        send(0,0,0, 2,2,0, 1, 0, 6'h04, nf, 6'h00, "R5 R9");

        // R11: offers while busy are ignored
        send(1,1,1, 3,3,3, 3, 0, 6'h00, 36'h0, 6'h00, "R11");
        in_valid = 1'b1; in_np = 3'd5; dst_x = 2'd0; nbr_fault = 36'hfffffffff;
        @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;

        // random routes, look-ahead port always minimal toward destination
        for (int n = 0; n < 60; n++) begin
            int cx, cy, cz, dx, dy, dz, np, m, cnt, pick;
            cx = $urandom_range(0, NX-1); cy = $urandom_range(0, NY-1); cz = $urandom_range(0, NZ-1);
            dx = $urandom_range(0, NX-1); dy = $urandom_range(0, NY-1); dz = $urandom_range(0, NZ-1);
            m = mmask(cx, cy, cz, dx, dy, dz);
            np = 0; cnt = 0;
            for (int q = 1; q <= 6; q++) if (((m >> (q - 1)) & 1) == 1) cnt++;
            if (cnt > 0) begin
                pick = $urandom_range(0, cnt - 1);
                for (int q = 1; q <= 6; q++)
                    if (((m >> (q - 1)) & 1) == 1) begin
                        if (pick == 0) np = q;
                        pick--;
                    end
            end
            send(cx, cy, cz, dx, dy, dz, np, $urandom_range(0, 6),
                 6'($urandom & $urandom), {4'($urandom & $urandom), 32'($urandom & $urandom)},
                 6'($urandom), "R3 R5 R9 random");
        end

        while (expq.size() > 0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(seen == sent, "R11", $sformatf("results actual=%0d expected=%0d", seen, sent));
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule